// File: doc/BRIEF.md
# Fetch-Stage Next-PC Predictor with Late Direction Override

This block picks the address that the fetch stage reads next. A small direct-mapped target buffer is read with the current fetch address in the same cycle. When the buffer holds a valid entry whose stored address equals the whole fetch address, and that entry's 2-bit counter leans taken, the stored target becomes the next address. In every other case the next address is the fetch address plus four. Only taken control transfers are ever placed in the buffer, so ordinary instructions never steer fetch away from the sequential path.

One cycle later, once the fetched instruction is decoded, a larger table of 2-bit direction counters is read with that instruction's address. If the table's opinion differs from what the buffer did, the block raises a late redirect. It goes to the decoded target when the table says taken and the buffer did not redirect. It goes to the fall-through address when the table says not taken and the buffer did redirect.

Both structures learn only from branches resolved in the execute stage. A resolved mispredict also drives the redirect output, with the corrected path, and it takes precedence over any late redirect raised in the same cycle.

Top module: `next_pc_predictor`

## Requirements
- R1: After reset, every buffer entry is invalid, so next_pc equals fetch_pc+4 for any fetch_pc, and redirect_valid stays low until something is fetched or resolved. Every direction-table counter resets to 01 (weakly not-taken).
- R2: A buffer lookup hits only if the entry at index fetch_pc[BUF_IDX_W+1:2] is valid and its stored address equals all PC_W bits of fetch_pc. An address that shares the index but differs in any upper bit misses and yields fetch_pc+4.
- R3: On a hit, next_pc is the stored target when the entry's counter bit 1 is set (10 or 11), and fetch_pc+4 when it is clear (00 or 01).
- R4: A taken resolve (ex_valid=1, ex_taken=1) that misses the buffer writes the entry at its index with valid, the full ex_pc, ex_target and counter 10. Any entry previously at that index is replaced.
- R5: A not-taken resolve that hits the buffer keeps the entry and only decrements its counter. A not-taken resolve that misses writes nothing into the buffer.
- R6: All counters are 2-bit saturating, with 11 strongly taken, 10 weakly taken, 01 weakly not-taken and 00 strongly not-taken. Taken increments without passing 11, and not-taken decrements without passing 00. A taken resolve that hits also rewrites the stored target.
- R7: In the cycle after a fetch with fetch_valid=1, if dec_branch=1, the direction-table counter at index pc[DIR_IDX_W+1:2] has bit 1 set, and the buffer did not redirect that fetch, then redirect_valid=1 and redirect_pc=dec_target.
- R8: In the cycle after a fetch, if dec_branch=1, the table counter has bit 1 clear, and the buffer did redirect that fetch, then redirect_valid=1 and redirect_pc is the fetched address plus four. The table wins.
- R9: When ex_valid=1 and ex_mispredict=1, redirect_valid=1 and redirect_pc is ex_target if ex_taken=1, else ex_pc+4. This holds whatever the decode stage asks for in the same cycle.
- R10: No late redirect occurs when dec_branch=0, or when the table and the buffer agree on direction.
- R11: Neither structure changes while ex_valid=0, whatever the other resolve inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | fetch_pc carries a real fetch this cycle |
| fetch_pc | input | PC_W | Address being fetched |
| next_pc | output | PC_W | Predicted next fetch address, same cycle |
| dec_branch | input | 1 | Instruction fetched last cycle decodes as a branch |
| dec_target | input | PC_W | Computed target of that decoded branch |
| ex_valid | input | 1 | A branch resolves this cycle |
| ex_taken | input | 1 | Resolved direction |
| ex_mispredict | input | 1 | The resolved branch was mispredicted |
| ex_pc | input | PC_W | Address of the resolved branch |
| ex_target | input | PC_W | Resolved target address |
| redirect_valid | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | PC_W | Address to restart fetch from |

## Verification
The bench sets up an alias pair that shares both the buffer index and the table index. This exposes a design that compares only part of the address, which would redirect the alias to a foreign target. It also exposes a design that fails to overwrite on insertion. It drives counters past both ends, which catches a wrapping counter that flips a strongly held prediction. It arranges a buffer hit that the table disagrees with, which catches a design that lets the buffer win or skips the override. It lines up a mispredict with a pending late redirect, so that inverted priority would send fetch to the decoded target instead of the corrected path. It also offers a full resolve with ex_valid low, which shows up any update that is not gated by ex_valid.

// File: rtl/next_pc_predictor.sv
`timescale 1ns/1ps
module next_pc_predictor #(
  parameter int PC_W      = 32,
  parameter int BUF_IDX_W = 4,
  parameter int DIR_IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] next_pc,
  input  logic            dec_branch,
  input  logic [PC_W-1:0] dec_target,
  input  logic            ex_valid,
  input  logic            ex_taken,
  input  logic            ex_mispredict,
  input  logic [PC_W-1:0] ex_pc,
  input  logic [PC_W-1:0] ex_target,
  output logic            redirect_valid,
  output logic [PC_W-1:0] redirect_pc
);
  localparam int BUF_N = 1 << BUF_IDX_W;
  localparam int DIR_N = 1 << DIR_IDX_W;
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic            buf_vld [BUF_N];
  logic [PC_W-1:0] buf_tag [BUF_N];
  logic [PC_W-1:0] buf_tgt [BUF_N];
  logic [1:0]      buf_ctr [BUF_N];
  logic [1:0]      dir_ctr [DIR_N];

  function automatic logic [1:0] sat_step(input logic [1:0] c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    else    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  // fetch lookup
  logic [BUF_IDX_W-1:0] f_idx;
  logic                 f_hit, f_take;
  assign f_idx   = fetch_pc[BUF_IDX_W+1:2];
  assign f_hit   = buf_vld[f_idx] && (buf_tag[f_idx] == fetch_pc);
  assign f_take  = f_hit && buf_ctr[f_idx][1];
  assign next_pc = f_take ? buf_tgt[f_idx] : fetch_pc + STEP;

  // decode stage
  logic            s2_valid, s2_pred;
  logic [PC_W-1:0] s2_pc;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_pred  <= 1'b0;
      s2_pc    <= '0;
    end else begin
      s2_valid <= fetch_valid;
      s2_pred  <= f_take;
      s2_pc    <= fetch_pc;
    end
  end

  logic [DIR_IDX_W-1:0] d_idx;
  logic d_taken, d_active, late_take, late_drop, ex_fix;
  logic [PC_W-1:0] ex_right;
  assign d_idx     = s2_pc[DIR_IDX_W+1:2];
  assign d_taken   = dir_ctr[d_idx][1];
  assign d_active  = s2_valid && dec_branch;
  assign late_take = d_active &&  d_taken && !s2_pred;
  assign late_drop = d_active && !d_taken &&  s2_pred;
  assign ex_fix    = ex_valid && ex_mispredict;
  assign ex_right  = ex_taken ? ex_target : ex_pc + STEP;

  assign redirect_valid = ex_fix || late_take || late_drop;
  assign redirect_pc    = ex_fix    ? ex_right   :
                          late_take ? dec_target : s2_pc + STEP;

  // resolve updates
  logic [BUF_IDX_W-1:0] e_bidx;
  logic [DIR_IDX_W-1:0] e_didx;
  logic                 e_hit;
  assign e_bidx = ex_pc[BUF_IDX_W+1:2];
  assign e_didx = ex_pc[DIR_IDX_W+1:2];
  assign e_hit  = buf_vld[e_bidx] && (buf_tag[e_bidx] == ex_pc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BUF_N; i++) begin
        buf_vld[i] <= 1'b0;
        buf_tag[i] <= '0;
        buf_tgt[i] <= '0;
        buf_ctr[i] <= 2'b00;
      end
    end else if (ex_valid) begin
      if (e_hit) begin
        buf_ctr[e_bidx] <= sat_step(buf_ctr[e_bidx], ex_taken);
        if (ex_taken) buf_tgt[e_bidx] <= ex_target;
      end else if (ex_taken) begin
        buf_vld[e_bidx] <= 1'b1;
        buf_tag[e_bidx] <= ex_pc;
        buf_tgt[e_bidx] <= ex_target;
        buf_ctr[e_bidx] <= 2'b10;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DIR_N; i++) dir_ctr[i] <= 2'b01;
    end else if (ex_valid) begin
      dir_ctr[e_didx] <= sat_step(dir_ctr[e_didx], ex_taken);
    end
  end
endmodule

// File: rtl/next_pc_predictor_checks.sv
`timescale 1ns/1ps
module next_pc_predictor_checks #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fetch_valid,
  input logic [PC_W-1:0] fetch_pc,
  input logic [PC_W-1:0] next_pc,
  input logic            ex_valid,
  input logic            ex_taken,
  input logic            ex_mispredict,
  input logic [PC_W-1:0] ex_pc,
  input logic [PC_W-1:0] ex_target,
  input logic            redirect_valid,
  input logic [PC_W-1:0] redirect_pc
);
  AST_CLEAN_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> next_pc == fetch_pc + PC_W'(4)); // R1

  AST_EXEC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_mispredict) |->
      (redirect_valid && redirect_pc == (ex_taken ? ex_target : ex_pc + PC_W'(4)))); // R9

  AST_LATE_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && !(ex_valid && ex_mispredict)) |-> $past(fetch_valid)); // R7

  AST_IDLE_NO_LEARN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(ex_valid) && $stable(fetch_pc)) |-> $stable(next_pc)); // R11
endmodule

bind next_pc_predictor next_pc_predictor_checks #(.PC_W(PC_W)) u_checks (.*);

// File: tb/tb_next_pc_predictor.sv
`timescale 1ns/1ps
module tb_next_pc_predictor;
  localparam int PC_W = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_valid = 1'b0, dec_branch = 1'b0;
  logic ex_valid = 1'b0, ex_taken = 1'b0, ex_mispredict = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0, dec_target = '0, ex_pc = '0, ex_target = '0;
  logic [PC_W-1:0] next_pc, redirect_pc;
  logic redirect_valid;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  next_pc_predictor dut (.*);

  task automatic expect_val(string req, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic resolve(logic [PC_W-1:0] pc, logic tk, logic [PC_W-1:0] tgt, logic vld = 1'b1);
    @(negedge clk);
    ex_valid = vld; ex_taken = tk; ex_pc = pc; ex_target = tgt; ex_mispredict = 1'b0;
    @(negedge clk);
    ex_valid = 1'b0; ex_taken = 1'b0;
  endtask

  task automatic look(string req, logic [PC_W-1:0] pc, logic [PC_W-1:0] exp);
    @(negedge clk);
    fetch_pc = pc;
    #1 expect_val(req, next_pc, exp);
  endtask

  // fetch pc, then present decode next cycle; leaves decode inputs driven
  task automatic fetch_decode(logic [PC_W-1:0] pc, logic br, logic [PC_W-1:0] tgt);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = pc;
    @(negedge clk);
    fetch_valid = 1'b0; dec_branch = br; dec_target = tgt;
    #1;
  endtask

  task automatic test_reset();
    look("R1", 32'h100, 32'h104);
    expect_val("R1", {31'd0, redirect_valid}, 32'd0);
    // table starts weakly not-taken: decoded branch with buffer miss -> no redirect
    fetch_decode(32'h100, 1'b1, 32'h900);
    expect_val("R1", {31'd0, redirect_valid}, 32'd0);
    dec_branch = 1'b0;
  endtask

  task automatic test_alias_override();
    resolve(32'h100, 1'b1, 32'h180);
    look("R4", 32'h100, 32'h180);
    resolve(32'h1100, 1'b1, 32'h1180);   // same index, replaces entry
    look("R4", 32'h1100, 32'h1180);
    look("R2", 32'h100, 32'h104);
    // table at shared index now 11; buffer missed 0x100 -> late redirect (R7)
    fetch_decode(32'h100, 1'b1, 32'h180);
    expect_val("R7", {31'd0, redirect_valid}, 32'd1);
    expect_val("R7", redirect_pc, 32'h180);
    dec_branch = 1'b0;
    // non-branch: no redirect
    fetch_decode(32'h100, 1'b0, 32'h180);
    expect_val("R10", {31'd0, redirect_valid}, 32'd0);
    // agreement: buffer hit taken, table taken
    fetch_decode(32'h1100, 1'b1, 32'h1180);
    expect_val("R10", {31'd0, redirect_valid}, 32'd0);
    dec_branch = 1'b0;
  endtask

  task automatic test_table_wins();
    resolve(32'h204, 1'b1, 32'h280);     // buffer 10, table 10
    resolve(32'h1204, 1'b0, 32'h0);      // misses buffer, table 01
    resolve(32'h1204, 1'b0, 32'h0);      // table 00
    look("R5", 32'h1204, 32'h1208);      // not-taken miss inserted nothing
    fetch_decode(32'h204, 1'b1, 32'h280);
    expect_val("R8", {31'd0, redirect_valid}, 32'd1);
    expect_val("R8", redirect_pc, 32'h208);
    dec_branch = 1'b0;
  endtask

  task automatic test_saturation();
    resolve(32'h308, 1'b1, 32'h380);     // 10
    resolve(32'h308, 1'b1, 32'h380);     // 11
    resolve(32'h308, 1'b1, 32'h390);     // stays 11, target rewritten
    resolve(32'h308, 1'b0, 32'h0);       // 10
    look("R6", 32'h308, 32'h390);
    resolve(32'h308, 1'b0, 32'h0);       // 01
    look("R3", 32'h308, 32'h30C);
    resolve(32'h308, 1'b0, 32'h0);       // 00
    resolve(32'h308, 1'b0, 32'h0);       // stays 00
    resolve(32'h308, 1'b1, 32'h3A0);     // 01, entry kept
    look("R6", 32'h308, 32'h30C);
    resolve(32'h308, 1'b1, 32'h3A0);     // 10
    look("R5", 32'h308, 32'h3A0);
  endtask

  task automatic test_idle_resolve();
    resolve(32'h40C, 1'b1, 32'h480, 1'b0);
    look("R11", 32'h40C, 32'h410);
  endtask

  task automatic test_exec_priority();
    fetch_decode(32'h100, 1'b1, 32'h180);  // would redirect late to 0x180
    ex_valid = 1'b1; ex_mispredict = 1'b1; ex_taken = 1'b1;
    ex_pc = 32'h600; ex_target = 32'h700;
    #1 expect_val("R9", {31'd0, redirect_valid}, 32'd1);
    expect_val("R9", redirect_pc, 32'h700);
    @(negedge clk);
    dec_branch = 1'b0; ex_taken = 1'b0; ex_pc = 32'h610;
    #1 expect_val("R9", redirect_pc, 32'h614);
    @(negedge clk);
    ex_valid = 1'b0; ex_mispredict = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_alias_override();
    test_table_wins();
    test_saturation();
    test_idle_resolve();
    test_exec_priority();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule